// File: doc/BRIEF.md
# Two-Input Gate Identifier

The block works out which logic function an external two-input gate performs. On a rising edge of its enable input it drives the gate's two inputs through the four input pairs in turn. For each pair it waits a fixed number of settle cycles, then samples the gate's response through a synchronizer. The four samples make up a truth table. That table is matched against six known gate signatures, and a 4-bit code for the gate type is reported together with a one-cycle done pulse.

The enable input has to stay high for the whole sweep. If it drops early, the sweep is abandoned and the gate's inputs are released back to zero. The reported code stays in place until the next rising edge of enable starts a new identification.

Top module: `gate_probe`

## Requirements
- R1: After reset, and whenever no sweep is running, both drive outputs are 0, `code_o` is 0 and `done_o` is 0.
- R2: A sweep starts only on a rising edge of `start_i`. Keeping `start_i` high after a sweep has finished starts no further sweep.
- R3: During a sweep, the pair index k steps 0, 1, 2, 3. Index k is held for SETTLE_CYCLES (default 16) cycles, with `drv_a_o` = bit 0 of k and `drv_b_o` = bit 1 of k.
- R4: The response passes through a two-flop synchronizer and is sampled only on the last cycle of each settle window. Disturbances on `resp_i` early in the window do not affect the result. The sample for pair k goes into truth-table bit k.
- R5: Truth table to `code_o`: 1000 gives 1 (AND), 1110 gives 2 (OR), 0110 gives 3 (XOR), 0111 gives 4 (NAND), 0001 gives 5 (NOR), 1001 gives 6 (XNOR). Each table is written as bit 3 down to bit 0.
- R6: Any other truth table (for example 0000 or 1010) reports code 0.
- R7: `done_o` is high for exactly one cycle. It goes high 4*SETTLE_CYCLES+1 clock edges after the edge that samples the rising edge of `start_i`, and `code_o` is valid from that cycle on.
- R8: `code_o` holds its value until the next rising edge of `start_i`, which clears it to 0 for the duration of the new sweep.
- R9: If `start_i` goes low during a sweep, the sweep stops. The drive outputs return to 0 on the next cycle, no done pulse occurs and `code_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enable; a rising edge starts a sweep, and it must stay high throughout |
| drv_a_o | output | 1 | First input of the gate under test (pair index bit 0) |
| drv_b_o | output | 1 | Second input of the gate under test (pair index bit 1) |
| resp_i | input | 1 | Output of the gate under test |
| code_o | output | 4 | Gate type code (0 means unknown) |
| done_o | output | 1 | One-cycle pulse when `code_o` becomes valid |

## Verification
The modelled gate's output is made to glitch for three cycles after every drive change. A design that samples too early, or in the same edge that changes the drives, records the glitch and reports the wrong code. The drive pair is checked in the middle of each settle window, which catches a swapped bit order or a skipped step. Two non-gate tables (constant 0 and a plain buffer) must give code 0; a design with a loose default would claim a match. The bench also checks the exact done latency, that no second sweep starts while enable stays high, and that dropping enable mid-sweep releases the drives and suppresses done. A design that ignored the abort would still report a code.

// File: rtl/gate_probe_pkg.sv
package gate_probe_pkg;

  typedef enum logic [3:0] {
    GC_NONE = 4'd0,
    GC_AND  = 4'd1,
    GC_OR   = 4'd2,
    GC_XOR  = 4'd3,
    GC_NAND = 4'd4,
    GC_NOR  = 4'd5,
    GC_XNOR = 4'd6
  } gate_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;

  // bit k = response for input pair k = {b,a}
  localparam logic [3:0] SIG_AND  = 4'b1000;
  localparam logic [3:0] SIG_OR   = 4'b1110;
  localparam logic [3:0] SIG_XOR  = 4'b0110;
  localparam logic [3:0] SIG_NAND = 4'b0111;
  localparam logic [3:0] SIG_NOR  = 4'b0001;
  localparam logic [3:0] SIG_XNOR = 4'b1001;

  function automatic gate_code_e classify(input logic [3:0] tt);
    gate_code_e c;
    case (tt)
      SIG_AND:  c = GC_AND;
      SIG_OR:   c = GC_OR;
      SIG_XOR:  c = GC_XOR;
      SIG_NAND: c = GC_NAND;
      SIG_NOR:  c = GC_NOR;
      SIG_XNOR: c = GC_XNOR;
      default:  c = GC_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/gp_seq.sv
module gp_seq
  import gate_probe_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       resp_s_i,
  output logic [1:0] drv_o,
  output logic [3:0] tt_o,
  output logic       tt_vld_o,
  output logic       sweep_start_o,
  output logic       busy_o
);

  localparam int TMR_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SETTLE_CYCLES - 1);

  seq_st_e          st_q;
  logic [1:0]       idx_q;
  logic [TMR_W-1:0] tmr_q;
  logic [3:0]       tt_q;
  logic             start_q;
  logic             start_rise;

  assign start_rise = start_i && !start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
      tt_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_i;
      case (st_q)
        ST_IDLE: begin
          if (start_rise) begin
            st_q  <= ST_RUN;
            idx_q <= '0;
            tmr_q <= '0;
            tt_q  <= '0;
          end
        end
        ST_RUN: begin
          if (!start_i) begin
            st_q <= ST_IDLE;
          end else if (tmr_q == TMR_LAST) begin
            // sample at window end, drives changed many edges earlier
            tt_q[idx_q] <= resp_s_i;
            tmr_q       <= '0;
            if (idx_q == 2'd3) st_q <= ST_FIN;
            else               idx_q <= idx_q + 2'd1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign drv_o         = (st_q == ST_RUN) ? idx_q : 2'b00;
  assign tt_o          = tt_q;
  assign tt_vld_o      = (st_q == ST_FIN);
  assign sweep_start_o = (st_q == ST_IDLE) && start_rise;
  assign busy_o        = (st_q == ST_RUN);

  // R3
  drv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && tmr_q != '0) |-> $stable(drv_o));

  // R3
  drv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q == ST_RUN) && tmr_q == '0)
      |-> (drv_o == $past(drv_o) + 2'd1));

  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !start_i) |=> (drv_o == 2'b00 && !tt_vld_o));

  // R3
  tmr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= TMR_LAST);

endmodule

// File: rtl/gp_match.sv
module gp_match
  import gate_probe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] tt_i,
  input  logic       tt_vld_i,
  input  logic       clr_i,
  output logic [3:0] code_o,
  output logic       done_o
);

  gate_code_e code_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= GC_NONE;
      done_q <= 1'b0;
    end else begin
      done_q <= tt_vld_i;
      if (clr_i)         code_q <= GC_NONE;
      else if (tt_vld_i) code_q <= classify(tt_i);
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tt_vld_i && !clr_i) |=> $stable(code_o));

  // R5
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= 4'd6);

endmodule

// File: rtl/gate_probe.sv
module gate_probe #(
  parameter int SETTLE_CYCLES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       drv_a_o,
  output logic       drv_b_o,
  input  logic       resp_i,
  output logic [3:0] code_o,
  output logic       done_o
);

  logic       resp_s;
  logic [1:0] drv;
  logic [3:0] tt;
  logic       tt_vld;
  logic       sweep_start;
  logic       busy;

  gp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (resp_i),
    .q_o    (resp_s)
  );

  gp_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .resp_s_i      (resp_s),
    .drv_o         (drv),
    .tt_o          (tt),
    .tt_vld_o      (tt_vld),
    .sweep_start_o (sweep_start),
    .busy_o        (busy)
  );

  gp_match u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tt_i     (tt),
    .tt_vld_i (tt_vld),
    .clr_i    (sweep_start),
    .code_o   (code_o),
    .done_o   (done_o)
  );

  assign drv_a_o = drv[0];
  assign drv_b_o = drv[1];

  // R1
  idle_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy) |-> (!drv_a_o && !drv_b_o));

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !tt_vld && $rose(start_i)) |=> busy);

  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_start |=> (code_o == 4'd0));

endmodule

// File: tb/gate_probe_bench.sv
module gate_probe_bench;

  localparam int S = 16;
  localparam int LAT = 4 * S + 2;

  // {truth table, expected code}
  localparam logic [7:0] VEC [0:7] = '{
    8'h81, 8'hE2, 8'h63, 8'h74, 8'h15, 8'h96, 8'h00, 8'hA0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic drv_a, drv_b;
  logic resp;
  logic [3:0] code;
  logic done;

  logic [3:0] dut_tt = 4'b0000;
  logic glitch_en = 1'b1;
  logic [1:0] drv_prev = 2'b00;
  int glit_cnt = 0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // external gate with a short disturbance after each input change
  assign resp = dut_tt[{drv_b, drv_a}] ^ (glitch_en && glit_cnt != 0);

  always @(posedge clk) begin
    drv_prev <= {drv_b, drv_a};
    if ({drv_b, drv_a} != drv_prev) glit_cnt <= 3;
    else if (glit_cnt != 0)         glit_cnt <= glit_cnt - 1;
  end

  gate_probe #(.SETTLE_CYCLES(S), .SYNC_STAGES(2)) u_gate_probe (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .drv_a_o (drv_a),
    .drv_b_o (drv_b),
    .resp_i  (resp),
    .code_o  (code),
    .done_o  (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // returns negedges until done seen (0 if none within limit)
  task automatic wait_done(input int limit, output int lat);
    lat = 0;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      if (done) begin
        lat = c;
        break;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lat;
    int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(code == 4'd0, "R1 code", code, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check({drv_b, drv_a} == 2'b00, "R1 drv", {drv_b, drv_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 table walk, glitches active (R4)
    for (int i = 0; i < 8; i++) begin
      dut_tt = VEC[i][7:4];
      start = 1'b1;
      wait_done(LAT + 10, lat);
      check(lat == LAT, "R7 latency", lat, LAT);
      check(code == VEC[i][3:0], (VEC[i][3:0] == 0) ? "R6 code" : "R5 code",
            code, VEC[i][3:0]);
      @(negedge clk);
      check(done == 1'b0, "R7 pulse", done, 0);
      start = 1'b0;
      repeat (3) @(negedge clk);
      check({drv_b, drv_a} == 2'b00, "R1 idle drv", {drv_b, drv_a}, 0);
    end

    // R3 drive order, sampled mid window
    dut_tt = 4'b0110;
    start = 1'b1;
    for (int k = 0; k < 4; k++) begin
      repeat ((k == 0) ? (S / 2) : S) @(negedge clk);
      check({drv_b, drv_a} == k[1:0], "R3 drv pair", {drv_b, drv_a}, k);
    end
    wait_done(LAT, lat);
    check(code == 4'd3, "R4 xor", code, 3);

    // R2 enable held high: no restart
    seen = 0;
    for (int c = 0; c < 3 * LAT; c++) begin
      @(negedge clk);
      if (done || drv_a || drv_b) seen++;
    end
    check(seen == 0, "R2 no restart", seen, 0);
    // R8 held value
    check(code == 4'd3, "R8 hold", code, 3);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(code == 4'd3, "R8 hold low", code, 3);
    // R8 clear on new start
    dut_tt = 4'b1000;
    start = 1'b1;
    @(negedge clk);
    check(code == 4'd0, "R8 clear", code, 0);

    // R9 abort mid sweep
    repeat (S + 4) @(negedge clk);
    check({drv_b, drv_a} == 2'b01, "R9 pre drv", {drv_b, drv_a}, 1);
    start = 1'b0;
    @(negedge clk);
    check({drv_b, drv_a} == 2'b00, "R9 drv", {drv_b, drv_a}, 0);
    seen = 0;
    for (int c = 0; c < 2 * LAT; c++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check(seen == 0, "R9 no done", seen, 0);
    check(code == 4'd0, "R9 code", code, 0);

    // R4 without disturbance, NOR
    glitch_en = 1'b0;
    dut_tt = 4'b0001;
    start = 1'b1;
    wait_done(LAT + 10, lat);
    check(code == 4'd5, "R4 nor", code, 5);
    start = 1'b0;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule